// File: doc/BRIEF.md
# Wavefront Lane-State Initializer

This block builds the starting state of one wavefront inside a workgroup. A request carries the workgroup's clipped x and y extents, its total work-item count, the wavefront's index within the workgroup, the workgroup's linear ID with the grid's x and y extents, and the per-item private and spill sizes. The block accepts the request on a start strobe. It splits the linear workgroup ID into three coordinates and finds where the wavefront's first lane falls in the workgroup. It then streams one lane per clock with that lane's activity flag, its x/y/z work-item ID and its flat ID. The last lane carries a done pulse.

Two running allocators hand out the private and spill base addresses. Each accepted wavefront receives the current pointer value, and the pointer then moves on by the per-item size times the wavefront width. The barrier slot count is the number of wavefronts the workgroup needs. Both dividers run serially and are reused, so the datapath holds no combinational divider or multiplier.

Top module: `wf_lane_init`

## Requirements
- R1: Lane k of wavefront w has `lane_active_o` = 1 exactly when k + w*WF_SIZE < `total_i`. Inactive lanes are still streamed.
- R2: With L = k + w*WF_SIZE, a lane's `id_x_o` is L mod sx, `id_y_o` is (L div sx) mod sy and `id_z_o` is L div (sx*sy).
- R3: `flat_id_o` equals id_z*sx*sy + id_y*sx + id_x for every streamed lane.
- R4: `bar_slots_o` equals ceil(`total_i` / WF_SIZE) while the wavefront streams.
- R5: `priv_base_o` shows the private pointer as it stood when the request was accepted. That pointer then grows by `priv_item_i`*WF_SIZE.
- R6: `spill_base_o` and the spill pointer follow the rule of R5 with `spill_item_i`, independently of the private pointer.
- R7: After acceptance, lanes 0 to WF_SIZE-1 stream in order on consecutive cycles with `lane_valid_o` high. `done_o` is high only with lane WF_SIZE-1. The cycle after it, `lane_valid_o` and `busy_o` are low. After reset, `busy_o`, `lane_valid_o` and `done_o` are low.
- R8: `start_i` has no effect while `busy_o` is high. The stream, the bases and the later pointer values are unchanged.
- R9: While streaming, `wg_x_o` = g mod nx, `wg_y_o` = (g div nx) mod ny and `wg_z_o` = g div (nx*ny), where g = `wg_id_i`.
- R10: `alloc_load_i` loads both pointers from `priv_start_i` and `spill_start_i`. The next accepted wavefront receives these values as its bases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, taken when idle |
| wave_idx_i | input | LIN_W-log2(WF_SIZE) | Wavefront index within the workgroup |
| dim_x_i | input | LIN_W | Clipped workgroup x extent sx (nonzero) |
| dim_y_i | input | LIN_W | Clipped workgroup y extent sy (nonzero) |
| total_i | input | LIN_W | Work items in the workgroup |
| grid_x_i | input | LIN_W | Workgroups along x, nx (nonzero) |
| grid_y_i | input | LIN_W | Workgroups along y, ny (nonzero) |
| wg_id_i | input | LIN_W | Linear workgroup ID |
| priv_item_i | input | SZ_W | Private bytes per work item |
| spill_item_i | input | SZ_W | Spill bytes per work item |
| alloc_load_i | input | 1 | Load both allocator pointers |
| priv_start_i | input | ADDR_W | Private pointer load value |
| spill_start_i | input | ADDR_W | Spill pointer load value |
| busy_o | output | 1 | Request in progress |
| priv_base_o | output | ADDR_W | Private base of the current wavefront |
| spill_base_o | output | ADDR_W | Spill base of the current wavefront |
| bar_slots_o | output | LIN_W-log2(WF_SIZE)+1 | Barrier slot count |
| wg_x_o | output | LIN_W | Workgroup x coordinate |
| wg_y_o | output | LIN_W | Workgroup y coordinate |
| wg_z_o | output | LIN_W | Workgroup z coordinate |
| lane_valid_o | output | 1 | A lane record is present |
| lane_o | output | log2(WF_SIZE) | Lane number |
| lane_active_o | output | 1 | Lane is in the initial mask |
| id_x_o | output | LIN_W | Work-item x ID |
| id_y_o | output | LIN_W | Work-item y ID |
| id_z_o | output | LIN_W | Work-item z ID |
| flat_id_o | output | LIN_W | Flat work-item ID |
| done_o | output | 1 | Last lane of the wavefront |

## Verification
The assertions check several properties on every cycle:
- a divider remainder is below its divisor;
- the x ID stays below sx;
- the flat ID agrees with the three IDs;
- the lanes step without gaps and the stream ends cleanly after done;
- the activity mask never turns back on within a wavefront;
- the bases hold while a request arrives during a busy period.

The bench scenarios are the only place that shows the arithmetic is right. This covers the mask boundary that falls mid-wavefront, degenerate 1x1 and wide-x shapes, the workgroup coordinates, the ceiling slot count, and pointers that advance once per accepted wavefront and honour a reload.

// File: rtl/wfi_pkg.sv
package wfi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV1 = 2'd1,
    ST_DIV2 = 2'd2,
    ST_LANES = 2'd3
  } wfi_state_e;
endpackage

// File: rtl/wfi_divider.sv
module wfi_divider #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         go_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o,
  output logic         done_o
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     quot_q, rem_q, den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, done_q;
  logic [W:0]       rem_sh, diff;

  assign rem_sh = {rem_q, quot_q[W-1]};
  assign diff   = rem_sh - {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quot_q <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (go_i) begin
      quot_q <= num_i;
      den_q  <= den_i;
      rem_q  <= '0;
      cnt_q  <= CNT_W'(W);
      run_q  <= 1'b1;
      done_q <= 1'b0;
    end else if (run_q) begin
      rem_q  <= diff[W] ? rem_sh[W-1:0] : diff[W-1:0];
      quot_q <= {quot_q[W-2:0], ~diff[W]};
      cnt_q  <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign quot_o = quot_q;
  assign rem_o  = rem_q;
  assign done_o = done_q;

  AST_REM_BELOW_DEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (den_q != '0) |-> rem_o < den_q); // R2
endmodule

// File: rtl/wfi_lane_counter.sv
module wfi_lane_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] x0_i,
  input  logic [W-1:0] y0_i,
  input  logic [W-1:0] z0_i,
  input  logic [W:0]   lin0_i,
  input  logic [W-1:0] sx_i,
  input  logic [W-1:0] sy_i,
  output logic [W-1:0] x_o,
  output logic [W-1:0] y_o,
  output logic [W-1:0] z_o,
  output logic [W:0]   lin_o
);
  logic [W-1:0] x_q, y_q, z_q;
  logic [W:0]   lin_q;
  logic         x_wrap, y_wrap;

  assign x_wrap = (x_q == sx_i - 1'b1);
  assign y_wrap = (y_q == sy_i - 1'b1);

  // nested wrap-around counters replace per-lane division
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q   <= '0;
      y_q   <= '0;
      z_q   <= '0;
      lin_q <= '0;
    end else if (load_i) begin
      x_q   <= x0_i;
      y_q   <= y0_i;
      z_q   <= z0_i;
      lin_q <= lin0_i;
    end else if (step_i) begin
      lin_q <= lin_q + 1'b1;
      if (x_wrap) begin
        x_q <= '0;
        if (y_wrap) begin
          y_q <= '0;
          z_q <= z_q + 1'b1;
        end else begin
          y_q <= y_q + 1'b1;
        end
      end else begin
        x_q <= x_q + 1'b1;
      end
    end
  end

  assign x_o   = x_q;
  assign y_o   = y_q;
  assign z_o   = z_q;
  assign lin_o = lin_q;

  AST_X_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> x_o < sx_i); // R2
  AST_Y_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> y_o < sy_i); // R2
endmodule

// File: rtl/wf_lane_init.sv
module wf_lane_init
  import wfi_pkg::*;
#(
  parameter int WF_SIZE = 64,
  parameter int LIN_W   = 16,
  parameter int SZ_W    = 16,
  parameter int ADDR_W  = 32,
  localparam int LOG_WF = $clog2(WF_SIZE),
  localparam int WAVE_W = LIN_W - LOG_WF,
  localparam int SLOT_W = LIN_W - LOG_WF + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WAVE_W-1:0] wave_idx_i,
  input  logic [LIN_W-1:0]  dim_x_i,
  input  logic [LIN_W-1:0]  dim_y_i,
  input  logic [LIN_W-1:0]  total_i,
  input  logic [LIN_W-1:0]  grid_x_i,
  input  logic [LIN_W-1:0]  grid_y_i,
  input  logic [LIN_W-1:0]  wg_id_i,
  input  logic [SZ_W-1:0]   priv_item_i,
  input  logic [SZ_W-1:0]   spill_item_i,
  input  logic              alloc_load_i,
  input  logic [ADDR_W-1:0] priv_start_i,
  input  logic [ADDR_W-1:0] spill_start_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] priv_base_o,
  output logic [ADDR_W-1:0] spill_base_o,
  output logic [SLOT_W-1:0] bar_slots_o,
  output logic [LIN_W-1:0]  wg_x_o,
  output logic [LIN_W-1:0]  wg_y_o,
  output logic [LIN_W-1:0]  wg_z_o,
  output logic              lane_valid_o,
  output logic [LOG_WF-1:0] lane_o,
  output logic              lane_active_o,
  output logic [LIN_W-1:0]  id_x_o,
  output logic [LIN_W-1:0]  id_y_o,
  output logic [LIN_W-1:0]  id_z_o,
  output logic [LIN_W-1:0]  flat_id_o,
  output logic              done_o
);
  localparam int NDIV = 2;  // 0: lane chain, 1: workgroup chain

  wfi_state_e        state_q;
  logic [WAVE_W-1:0] wave_q;
  logic [LIN_W-1:0]  sx_q, sy_q, total_q, nx_q, ny_q, g_q;
  logic [LIN_W-1:0]  x0_q, lq_q, gq_q;
  logic [LIN_W-1:0]  wgx_q, wgy_q, wgz_q;
  logic [SLOT_W-1:0] slots_q;
  logic [ADDR_W-1:0] priv_ptr_q, spill_ptr_q, priv_base_q, spill_base_q;
  logic [LOG_WF-1:0] lane_q;
  logic              go_q, accept, div_done, cnt_load, last_lane;
  logic [LIN_W-1:0]  lin0;
  logic [LIN_W-1:0]  cx, cy, cz;
  logic [LIN_W:0]    clin;

  logic [LIN_W-1:0]  d_num  [NDIV];
  logic [LIN_W-1:0]  d_den  [NDIV];
  logic [LIN_W-1:0]  d_quot [NDIV];
  logic [LIN_W-1:0]  d_rem  [NDIV];
  logic [NDIV-1:0]   d_done;

  assign accept    = (state_q == ST_IDLE) && start_i;
  assign lin0      = {wave_q, {LOG_WF{1'b0}}};
  assign div_done  = d_done[0];
  assign last_lane = (lane_q == LOG_WF'(WF_SIZE - 1));
  assign cnt_load  = (state_q == ST_DIV2) && div_done;

  // first pass splits by x extent, second by y extent
  assign d_num[0] = (state_q == ST_DIV1) ? lin0 : lq_q;
  assign d_den[0] = (state_q == ST_DIV1) ? sx_q : sy_q;
  assign d_num[1] = (state_q == ST_DIV1) ? g_q  : gq_q;
  assign d_den[1] = (state_q == ST_DIV1) ? nx_q : ny_q;

  for (genvar i = 0; i < NDIV; i++) begin : g_div
    wfi_divider #(.W(LIN_W)) u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .go_i   (go_q),
      .num_i  (d_num[i]),
      .den_i  (d_den[i]),
      .quot_o (d_quot[i]),
      .rem_o  (d_rem[i]),
      .done_o (d_done[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wave_q  <= '0;
      sx_q    <= '0;
      sy_q    <= '0;
      total_q <= '0;
      nx_q    <= '0;
      ny_q    <= '0;
      g_q     <= '0;
      x0_q    <= '0;
      lq_q    <= '0;
      gq_q    <= '0;
      wgx_q   <= '0;
      wgy_q   <= '0;
      wgz_q   <= '0;
      slots_q <= '0;
      lane_q  <= '0;
      go_q    <= 1'b0;
    end else begin
      go_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          wave_q  <= wave_idx_i;
          sx_q    <= dim_x_i;
          sy_q    <= dim_y_i;
          total_q <= total_i;
          nx_q    <= grid_x_i;
          ny_q    <= grid_y_i;
          g_q     <= wg_id_i;
          slots_q <= SLOT_W'(({1'b0, total_i} + (LIN_W + 1)'(WF_SIZE - 1)) >> LOG_WF);
          go_q    <= 1'b1;
          state_q <= ST_DIV1;
        end
        ST_DIV1: if (div_done) begin
          x0_q    <= d_rem[0];
          lq_q    <= d_quot[0];
          wgx_q   <= d_rem[1];
          gq_q    <= d_quot[1];
          go_q    <= 1'b1;
          state_q <= ST_DIV2;
        end
        ST_DIV2: if (div_done) begin
          wgy_q   <= d_rem[1];
          wgz_q   <= d_quot[1];
          lane_q  <= '0;
          state_q <= ST_LANES;
        end
        ST_LANES: begin
          lane_q <= lane_q + 1'b1;
          if (last_lane) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // running allocators; reload wins over advance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      priv_ptr_q   <= '0;
      spill_ptr_q  <= '0;
      priv_base_q  <= '0;
      spill_base_q <= '0;
    end else begin
      if (accept) begin
        priv_base_q  <= priv_ptr_q;
        spill_base_q <= spill_ptr_q;
      end
      if (alloc_load_i) begin
        priv_ptr_q  <= priv_start_i;
        spill_ptr_q <= spill_start_i;
      end else if (accept) begin
        priv_ptr_q  <= priv_ptr_q  + (ADDR_W'(priv_item_i)  << LOG_WF);
        spill_ptr_q <= spill_ptr_q + (ADDR_W'(spill_item_i) << LOG_WF);
      end
    end
  end

  wfi_lane_counter #(.W(LIN_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cnt_load),
    .step_i (state_q == ST_LANES),
    .x0_i   (x0_q),
    .y0_i   (d_rem[0]),
    .z0_i   (d_quot[0]),
    .lin0_i ({1'b0, lin0}),
    .sx_i   (sx_q),
    .sy_i   (sy_q),
    .x_o    (cx),
    .y_o    (cy),
    .z_o    (cz),
    .lin_o  (clin)
  );

  assign busy_o        = (state_q != ST_IDLE);
  assign priv_base_o   = priv_base_q;
  assign spill_base_o  = spill_base_q;
  assign bar_slots_o   = slots_q;
  assign wg_x_o        = wgx_q;
  assign wg_y_o        = wgy_q;
  assign wg_z_o        = wgz_q;
  assign lane_valid_o  = (state_q == ST_LANES);
  assign lane_o        = lane_q;
  assign lane_active_o = clin < {1'b0, total_q};
  assign id_x_o        = cx;
  assign id_y_o        = cy;
  assign id_z_o        = cz;
  assign flat_id_o     = clin[LIN_W-1:0];
  assign done_o        = lane_valid_o && last_lane;

  AST_FLAT_CONSISTENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_valid_o |-> (48'(id_z_o) * 48'(sx_q) * 48'(sy_q) + 48'(id_y_o) * 48'(sx_q)
                      + 48'(id_x_o)) == 48'(flat_id_o)); // R3
  AST_LANE_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_valid_o && !done_o |=> lane_valid_o && (lane_o == $past(lane_o) + 1'b1)); // R7
  AST_END_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !lane_valid_o && !busy_o); // R7
  AST_MASK_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_valid_o && !lane_active_o && !done_o |=> !lane_active_o); // R1
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> $stable(priv_base_o) && $stable(spill_base_o)); // R8
endmodule

// File: tb/wf_lane_init_bench.sv
module wf_lane_init_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WF     = 64;
  localparam int LIN_W  = 16;
  localparam int SZ_W   = 16;
  localparam int ADDR_W = 32;
  localparam int WAVE_W = 10;
  localparam int SLOT_W = 11;
  localparam int WD_MAX = 100000;

  logic clk, rst_n, start, alloc_load;
  logic [WAVE_W-1:0] wave_idx;
  logic [LIN_W-1:0] dim_x, dim_y, total, grid_x, grid_y, wg_id;
  logic [SZ_W-1:0] priv_item, spill_item;
  logic [ADDR_W-1:0] priv_start, spill_start, priv_base, spill_base;
  logic busy, lane_valid, lane_active, done;
  logic [SLOT_W-1:0] bar_slots;
  logic [LIN_W-1:0] wg_x, wg_y, wg_z, id_x, id_y, id_z, flat_id;
  logic [5:0] lane;

  int n_tests = 0, n_fail = 0, cyc = 0;
  longint m_priv = 0, m_spill = 0;

  wf_lane_init u_wf_lane_init (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .wave_idx_i(wave_idx),
    .dim_x_i(dim_x), .dim_y_i(dim_y), .total_i(total), .grid_x_i(grid_x),
    .grid_y_i(grid_y), .wg_id_i(wg_id), .priv_item_i(priv_item),
    .spill_item_i(spill_item), .alloc_load_i(alloc_load),
    .priv_start_i(priv_start), .spill_start_i(spill_start), .busy_o(busy),
    .priv_base_o(priv_base), .spill_base_o(spill_base), .bar_slots_o(bar_slots),
    .wg_x_o(wg_x), .wg_y_o(wg_y), .wg_z_o(wg_z), .lane_valid_o(lane_valid),
    .lane_o(lane), .lane_active_o(lane_active), .id_x_o(id_x), .id_y_o(id_y),
    .id_z_o(id_z), .flat_id_o(flat_id), .done_o(done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_MAX) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_MAX);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic reload(input longint p, input longint s);
    @(negedge clk);
    alloc_load  = 1'b1;
    priv_start  = ADDR_W'(p);
    spill_start = ADDR_W'(s);
    @(negedge clk);
    alloc_load = 1'b0;
    m_priv  = p;
    m_spill = s;
  endtask

  task automatic run_wave(input int sx, input int sy, input int tot, input int w,
                          input int nx, input int ny, input int g,
                          input int pit, input int sit, input bit poke);
    longint eb_p, eb_s;
    eb_p = m_priv;
    eb_s = m_spill;
    m_priv  += longint'(pit) * WF;
    m_spill += longint'(sit) * WF;
    @(negedge clk);
    dim_x = LIN_W'(sx); dim_y = LIN_W'(sy); total = LIN_W'(tot);
    wave_idx = WAVE_W'(w); grid_x = LIN_W'(nx); grid_y = LIN_W'(ny);
    wg_id = LIN_W'(g); priv_item = SZ_W'(pit); spill_item = SZ_W'(sit);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!lane_valid) @(negedge clk);
    chk(priv_base == ADDR_W'(eb_p), "R5 priv_base", priv_base, eb_p);
    chk(spill_base == ADDR_W'(eb_s), "R6 spill_base", spill_base, eb_s);
    chk(bar_slots == SLOT_W'((tot + WF - 1) / WF), "R4 bar_slots", bar_slots, (tot + WF - 1) / WF);
    chk(wg_x == LIN_W'(g % nx), "R9 wg_x", wg_x, g % nx);
    chk(wg_y == LIN_W'((g / nx) % ny), "R9 wg_y", wg_y, (g / nx) % ny);
    chk(wg_z == LIN_W'(g / (nx * ny)), "R9 wg_z", wg_z, g / (nx * ny));
    for (int k = 0; k < WF; k++) begin
      int L, ex, ey, ez;
      L  = k + w * WF;
      ex = L % sx;
      ey = (L / sx) % sy;
      ez = L / (sx * sy);
      chk(lane_valid && lane == 6'(k), "R7 lane", lane_valid ? longint'(lane) : -1, k);
      chk(lane_active == (L < tot), "R1 active", lane_active, L < tot);
      chk(id_x == LIN_W'(ex), "R2 id_x", id_x, ex);
      chk(id_y == LIN_W'(ey), "R2 id_y", id_y, ey);
      chk(id_z == LIN_W'(ez), "R2 id_z", id_z, ez);
      chk(flat_id == LIN_W'(ez * sx * sy + ey * sx + ex), "R3 flat", flat_id, ez * sx * sy + ey * sx + ex);
      chk(done == (k == WF - 1), "R7 done", done, k == WF - 1);
      if (poke) begin
        chk(priv_base == ADDR_W'(eb_p), "R8 priv_base held", priv_base, eb_p);
        chk(spill_base == ADDR_W'(eb_s), "R8 spill_base held", spill_base, eb_s);
        if (k == 10) begin
          start = 1'b1;
          wave_idx = WAVE_W'(w + 5);
          dim_x = LIN_W'(sx + 3);
        end
        if (k == 12) start = 1'b0;
      end
      @(negedge clk);
    end
    chk(!lane_valid && !busy, "R7 idle after done", {lane_valid, busy}, 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; alloc_load = 1'b0;
    wave_idx = '0; dim_x = 16'd1; dim_y = 16'd1; total = '0;
    grid_x = 16'd1; grid_y = 16'd1; wg_id = '0;
    priv_item = '0; spill_item = '0; priv_start = '0; spill_start = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !lane_valid && !done, "R7 reset state", {busy, lane_valid, done}, 0);
    rst_n = 1'b1;
    reload(64'h1000, 64'h8000);                              // R10
    run_wave(8, 4, 96, 0, 3, 2, 5, 4, 2, 1'b0);              // all active
    run_wave(8, 4, 96, 1, 3, 2, 5, 4, 2, 1'b1);              // R1 boundary, R8 poke
    run_wave(5, 3, 105, 1, 4, 3, 17, 8, 1, 1'b0);
    run_wave(1, 1, 200, 3, 7, 5, 0, 3, 6, 1'b0);             // degenerate x/y
    reload(64'h40000, 64'h90000);                            // R10
    run_wave(100, 1, 100, 0, 2, 9, 35, 1, 0, 1'b0);
    run_wave(100, 1, 100, 1, 2, 9, 35, 2, 5, 1'b0);          // 36 active
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule